// File: doc/BRIEF.md
# Secure-gated FPU access control registers

This block keeps three system registers for a processor that has a secure monitor level and a hypervisor level. The registers are a secure gate register, a coprocessor access register and a hypervisor coprocessor trap register. Software reaches them over a small register bus. Each access on that bus carries the current exception level and a flag that says whether the access is non-secure. One bit in the secure gate register decides whether non-secure software may use the floating-point unit.

The gate is engaged when all of these hold: the monitor level exists, it runs the 32-bit state, the access is non-secure, and the gate bit is clear. While the gate is engaged, the FPU fields of the other two registers ignore writes. On reads, the coprocessor field returns zeros and the hypervisor field returns ones. The stored contents stay as they were.

The block also reports, combinationally, whether a floating-point instruction at the current level must trap as undefined, and at which level the trap is taken.

Top module: `fpu_access_gate`

## Requirements
- R1: Gating happens only when parameter MON_PRESENT is 1, parameter MON_IS_64 is 0, ns_i is 1 and bit 10 of the secure gate register (index 0) is 0. With MON_IS_64 set to 1, non-secure accesses update and read back the coprocessor and hypervisor registers unmasked.
- R2: After reset, all three registers read 0.
- R3: A gated write to the coprocessor access register (index 1) keeps bits [23:20] of the stored value. All other bits take the write data.
- R4: A gated read of index 1 returns bits [23:20] as 0. A later non-gated read shows that the stored bits are intact.
- R5: A gated write to the hypervisor trap register (index 2) keeps stored bits [11:10]. All other bits take the write data.
- R6: A gated read of index 2 returns bits [11:10] as 1. The stored bits are unchanged.
- R7: A write to index 0 with ns_i=1 has no effect. Index 3 always reads 0 and ignores writes.
- R8: Gating trap. When gating is engaged and cur_el_i is 2 or lower, trap_vld_o is 1. trap_el_o is 2 if cur_el_i is 2, and 1 otherwise.
- R9: Fallback trap, used when the gating trap does not fire. The field is bits [21:20] of the coprocessor access register.
  - If the field is 00 or 10, levels 0 and 1 trap to level 1.
  - If the field is 01, only level 0 traps to level 1.
  - Otherwise, when ns_i=1, cur_el_i is 2 or lower and bit 10 of the hypervisor register is 1, the trap goes to level 2.
  - Level 3 never traps. When no trap applies, trap_vld_o is 0.
- R10: With the gate bit set, or with ns_i=0, writes to indices 1 and 2 store all 32 bits and reads return the stored value unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | One-cycle write strobe |
| addr_i | input | 2 | Register index (0 gate, 1 coprocessor, 2 hypervisor) |
| wdata_i | input | 32 | Write data |
| ns_i | input | 1 | Access and state below monitor are non-secure |
| cur_el_i | input | 2 | Current exception level |
| rdata_o | output | 32 | Combinational read data |
| trap_vld_o | output | 1 | FP instruction must trap as undefined |
| trap_el_o | output | 2 | Target level of the FP trap |

## Verification
The hardest state to reach is the one where the gate masks a register field whose stored value differs from what a non-secure reader sees.

Getting there takes three steps. The bench first loads ones into the coprocessor FPU field through secure writes. It then issues non-secure writes that try to change the field. Finally it reads the field back both non-secure and secure, which shows that the masking and the retained storage are separate.

The trap table reprograms all three registers securely before each row. This lets gated, fallback and untrapped cases alternate.

// File: rtl/fag_pkg.sv
package fag_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned GATE_BIT = 10;
  localparam int unsigned CP_LO    = 20;
  localparam int unsigned CP_W     = 4;
  localparam int unsigned HYP_LO   = 10;
  localparam int unsigned HYP_W    = 2;
  localparam int unsigned CP10_LO  = 20;

  typedef enum logic [1:0] {
    IDX_GATE = 2'd0,
    IDX_CP   = 2'd1,
    IDX_HYP  = 2'd2,
    IDX_NONE = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/fag_gate.sv
module fag_gate #(
  parameter bit MON_PRESENT = 1'b1,
  parameter bit MON_IS_64   = 1'b0
) (
  input  logic ns_i,
  input  logic gate_bit_i,
  output logic gate_o
);
  generate
    if (MON_PRESENT && !MON_IS_64) begin : g_gated
      assign gate_o = ns_i & ~gate_bit_i;
    end else begin : g_open
      assign gate_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fag_regs.sv
module fag_regs
  import fag_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ns_i,
  input  logic          gate_i,
  output logic [DW-1:0] gate_q_o,
  output logic [DW-1:0] cp_q_o,
  output logic [DW-1:0] hyp_q_o
);
  localparam logic [DW-1:0] CP_M  = {{(DW-CP_W){1'b0}}, {CP_W{1'b1}}} << CP_LO;
  localparam logic [DW-1:0] HYP_M = {{(DW-HYP_W){1'b0}}, {HYP_W{1'b1}}} << HYP_LO;

  logic [DW-1:0] gate_q, cp_q, hyp_q;
  logic          wr_gate, wr_cp, wr_hyp;

  assign wr_gate = wr_en_i && (addr_i == IDX_GATE) && !ns_i;
  assign wr_cp   = wr_en_i && (addr_i == IDX_CP);
  assign wr_hyp  = wr_en_i && (addr_i == IDX_HYP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      cp_q   <= '0;
      hyp_q  <= '0;
    end else begin
      if (wr_gate) gate_q <= wdata_i;
      if (wr_cp)   cp_q   <= gate_i ? ((wdata_i & ~CP_M) | (cp_q & CP_M)) : wdata_i;
      if (wr_hyp)  hyp_q  <= gate_i ? ((wdata_i & ~HYP_M) | (hyp_q & HYP_M)) : wdata_i;
    end
  end

  assign gate_q_o = gate_q;
  assign cp_q_o   = cp_q;
  assign hyp_q_o  = hyp_q;

  AST_CP_FIELD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cp && gate_i) |=> (cp_q[CP_LO+CP_W-1:CP_LO] == $past(cp_q[CP_LO+CP_W-1:CP_LO]))); // R3
  AST_HYP_FIELD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hyp && gate_i) |=> (hyp_q[HYP_LO+HYP_W-1:HYP_LO] == $past(hyp_q[HYP_LO+HYP_W-1:HYP_LO]))); // R5
  AST_NS_GATE_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_GATE && ns_i) |=> $stable(gate_q)); // R7
endmodule

// File: rtl/fag_trap.sv
module fag_trap
  import fag_pkg::*;
(
  input  logic       gate_i,
  input  logic       ns_i,
  input  logic [1:0] cur_el_i,
  input  logic [1:0] cp10_i,
  input  logic       hyp_tcp_i,
  output logic       trap_vld_o,
  output logic [1:0] trap_el_o
);
  logic gate_trap, cp_trap, hyp_trap;

  assign gate_trap = gate_i && (cur_el_i <= 2'd2);
  assign cp_trap   = (cur_el_i <= 2'd1) &&
                     ((cp10_i == 2'b00) || (cp10_i == 2'b10) ||
                      ((cp10_i == 2'b01) && (cur_el_i == 2'd0)));
  assign hyp_trap  = ns_i && (cur_el_i <= 2'd2) && hyp_tcp_i;

  always_comb begin
    trap_vld_o = gate_trap | cp_trap | hyp_trap;
    if (gate_trap)     trap_el_o = (cur_el_i == 2'd2) ? 2'd2 : 2'd1;
    else if (cp_trap)  trap_el_o = 2'd1;
    else if (hyp_trap) trap_el_o = 2'd2;
    else               trap_el_o = 2'd0;
  end

  always_comb begin
    if (cur_el_i == 2'd3) AST_NO_TRAP_AT_MON: assert (!trap_vld_o); // R9
  end
endmodule

// File: rtl/fpu_access_gate.sv
module fpu_access_gate
  import fag_pkg::*;
#(
  parameter bit MON_PRESENT = 1'b1,
  parameter bit MON_IS_64   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          ns_i,
  input  logic [1:0]    cur_el_i,
  output logic [31:0]   rdata_o,
  output logic          trap_vld_o,
  output logic [1:0]    trap_el_o
);
  localparam logic [DW-1:0] CP_M  = {{(DW-CP_W){1'b0}}, {CP_W{1'b1}}} << CP_LO;
  localparam logic [DW-1:0] HYP_M = {{(DW-HYP_W){1'b0}}, {HYP_W{1'b1}}} << HYP_LO;

  logic          gate;
  logic [DW-1:0] gate_q, cp_q, hyp_q;

  fag_gate #(.MON_PRESENT(MON_PRESENT), .MON_IS_64(MON_IS_64)) u_gate (
    .ns_i       (ns_i),
    .gate_bit_i (gate_q[GATE_BIT]),
    .gate_o     (gate)
  );

  fag_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ns_i     (ns_i),
    .gate_i   (gate),
    .gate_q_o (gate_q),
    .cp_q_o   (cp_q),
    .hyp_q_o  (hyp_q)
  );

  fag_trap u_trap (
    .gate_i     (gate),
    .ns_i       (ns_i),
    .cur_el_i   (cur_el_i),
    .cp10_i     (cp_q[CP10_LO+1:CP10_LO]),
    .hyp_tcp_i  (hyp_q[HYP_LO]),
    .trap_vld_o (trap_vld_o),
    .trap_el_o  (trap_el_o)
  );

  always_comb begin
    unique case (addr_i)
      IDX_GATE: rdata_o = gate_q;
      IDX_CP:   rdata_o = gate ? (cp_q & ~CP_M) : cp_q;
      IDX_HYP:  rdata_o = gate ? (hyp_q | HYP_M) : hyp_q;
      default:  rdata_o = '0;
    endcase
  end

  AST_CP_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate && addr_i == IDX_CP) |-> (rdata_o[CP_LO+CP_W-1:CP_LO] == '0)); // R4
  AST_HYP_READS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate && addr_i == IDX_HYP) |-> (rdata_o[HYP_LO+HYP_W-1:HYP_LO] == '1)); // R6
  AST_GATE_TRAP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate && cur_el_i <= 2'd2) |-> (trap_vld_o && trap_el_o == ((cur_el_i == 2'd2) ? 2'd2 : 2'd1))); // R8
  AST_IDX3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_NONE) |-> (rdata_o == '0)); // R7
endmodule

// File: tb/sim_fpu_access_gate.sv
module sim_fpu_access_gate;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, ns = 1'b0;
  logic [1:0]  addr = '0, el = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata64;
  logic        tv, tv64;
  logic [1:0]  te, te64;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fpu_access_gate u0 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .ns_i(ns), .cur_el_i(el), .rdata_o(rdata),
    .trap_vld_o(tv), .trap_el_o(te));
  fpu_access_gate #(.MON_IS_64(1'b1)) u1 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .ns_i(ns), .cur_el_i(el), .rdata_o(rdata64),
    .trap_vld_o(tv64), .trap_el_o(te64));

  // {gate_bit, ns, el[1:0], cp10[1:0], hyp_tcp, exp_vld, exp_el[1:0]}
  localparam logic [9:0] TBL [13] = '{
    10'b0_1_01_11_0_1_01, 10'b0_1_10_11_0_1_10, 10'b0_1_00_11_0_1_01,
    10'b0_1_11_11_0_0_00, 10'b0_0_01_11_0_0_00, 10'b1_1_01_11_0_0_00,
    10'b1_1_00_01_0_1_01, 10'b1_1_01_01_0_0_00, 10'b1_1_01_00_0_1_01,
    10'b1_1_10_11_1_1_10, 10'b1_0_01_11_1_0_00, 10'b1_1_01_11_1_1_10,
    10'b1_1_10_00_0_0_00};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic n);
    @(negedge clk);
    addr = a; wdata = d; ns = n; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic n);
    @(negedge clk);
    addr = a; ns = n;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    for (int i = 0; i < 3; i++) begin
      rd(2'(i), 1'b0);
      chk("R2 reset read", rdata, 32'h0);
    end
    el = 2'd1; rd(2'd1, 1'b1);
    chk("R8 trap after reset", {29'd0, tv, te}, {29'd0, 1'b1, 2'd1});

    // trap table: secure programming, then probe
    for (int i = 0; i < 13; i++) begin
      logic [9:0] v;
      v = TBL[i];
      wr(2'd0, {21'd0, v[9], 10'd0}, 1'b0);
      wr(2'd1, {10'd0, v[5:4], 20'd0}, 1'b0);
      wr(2'd2, {21'd0, v[3], 10'd0}, 1'b0);
      @(negedge clk);
      ns = v[8]; el = v[7:6]; addr = 2'd3;
      #1;
      chk($sformatf("R8 R9 trap row %0d", i), {29'd0, tv, te}, {29'd0, v[2], v[1:0]});
    end

    // back to gated state, registers cleared
    wr(2'd0, 32'h0, 1'b0);
    wr(2'd1, 32'h00F0_0000, 1'b0);
    wr(2'd2, 32'h0, 1'b0);
    wr(2'd1, 32'hFF0F_FFFF, 1'b1);
    rd(2'd1, 1'b1);
    chk("R4 gated cp read", rdata, 32'hFF0F_FFFF);
    rd(2'd1, 1'b0);
    chk("R3 cp stored", rdata, 32'hFFFF_FFFF);
    rd(2'd1, 1'b1);
    chk("R1 64-bit monitor cp unmasked", rdata64, 32'hFF0F_FFFF);

    wr(2'd2, 32'hFFFF_FFFF, 1'b1);
    rd(2'd2, 1'b1);
    chk("R6 gated hyp read", rdata, 32'hFFFF_FFFF);
    rd(2'd2, 1'b0);
    chk("R5 hyp stored", rdata, 32'hFFFF_F3FF);
    chk("R1 64-bit monitor hyp", rdata64, 32'hFFFF_FFFF);

    wr(2'd0, 32'h0000_0400, 1'b1);
    rd(2'd0, 1'b0);
    chk("R7 ns gate write ignored", rdata, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF, 1'b0);
    rd(2'd3, 1'b0);
    chk("R7 index 3 reads zero", rdata, 32'h0);

    // ungated
    wr(2'd0, 32'h0000_0400, 1'b0);
    wr(2'd1, 32'h0000_0000, 1'b1);
    rd(2'd1, 1'b1);
    chk("R10 ungated cp write", rdata, 32'h0);
    wr(2'd2, 32'h0000_0000, 1'b1);
    wr(2'd2, 32'h0000_0C00, 1'b1);
    rd(2'd2, 1'b1);
    chk("R10 ungated hyp read", rdata, 32'h0000_0C00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule